// File: doc/BRIEF.md
# Seconds Counter with Periodic and Alarm Interrupts

This block is the timekeeping core of an always-on real-time clock. A slow oscillator, seen here as a one-cycle `tickEn` strobe in the system clock domain, drives a prescaler. Each time the prescaler wraps, a 32-bit seconds counter advances by one. The prescaler period is a parameter and defaults to 8 ticks. Software reaches the core through a small register port that uses byte offsets. It can stop the count, preload the prescaler and the seconds value, choose a periodic interrupt interval, and set a coarse alarm.

The alarm compares a 16-bit match value against seconds bits [22:7], so it resolves to 128 seconds. The periodic interval is written in eighths of a second, and only whole seconds take effect. Each event sets a sticky status bit whether or not it is enabled. A status bit is cleared by writing ones to the clear register. Each event has its own level-high interrupt output, which is the status bit gated by its enable bit.

Top module: `rtc_sec_core`

## Requirements
- R1: After reset, every register reads 0, both interrupt outputs are low, and the alarm does not fire from the reset values.
- R2: The divider (offset 0x08) advances on each `tickEn` cycle. When it reaches DIV_PERIOD-1 (default 7) it returns to 0 on the next tick, and the seconds counter (offset 0x0C) increments by one.
- R3: While control bit 0 (offset 0x1C) is 1, ticks are ignored. The divider and the seconds counter hold, and no periodic event occurs.
- R4: A write to the divider or to the seconds register loads the written value, with the divider keeping its low bits. A load takes priority over an increment in the same cycle.
- R5: Status bit 0 sets every N seconds, where N is the interval register (offset 0x00, 16 bits) shifted right by 3. Counting starts from reset or from the last interval write. An interval below 8 never sets it.
- R6: Status bit 1 sets one cycle after seconds[22:7] first equals the 16-bit match register (offset 0x04). It does not set again while the equality persists.
- R7: Status bits set whatever the enable register (offset 0x10, bit 0 periodic, bit 1 alarm) holds. `irqPeriodic` and `irqAlarm` are high exactly while the corresponding status bit (offset 0x14) and enable bit are both 1.
- R8: Writing to offset 0x18 clears each status bit whose data bit is 1 and leaves the others unchanged. If a set event and a clear reach the same bit in the same cycle, the set wins. Offset 0x18 reads 0.
- R9: Each register reads back what was written, with status read-only. Writes to the status offset or to an unmapped offset change nothing, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-cycle pulse per slow-oscillator tick |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 5 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data for `regAddr`, combinational |
| irqPeriodic | output | 1 | Level periodic interrupt |
| irqAlarm | output | 1 | Level alarm interrupt |

## Verification
The bound properties assume that `tickEn`, `regWe`, `regAddr` and `regWdata` are synchronous to `clk` and defined whenever reset is released. They also assume that a single register access completes in one cycle and that nothing else moves the seconds value. The bench changes every input only on the falling clock edge, keeps inputs at known values from time zero, and holds reset over several rising edges. Its one deliberate overlap drives a tick and a write in the same cycle, which probes the priority rules of R4 and R8.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;
  localparam int REG_AW    = 5;
  localparam int REG_DW    = 32;
  localparam int SEC_W     = 32;
  localparam int ALARM_LSB = 7;
  localparam int ALARM_W   = 16;
  localparam int PER_SHIFT = 3;
  localparam int IRQ_N     = 2;
  localparam int IDX_PER   = 0;
  localparam int IDX_ALM   = 1;

  localparam logic [REG_AW-1:0] OFS_PERIOD = 5'h00;
  localparam logic [REG_AW-1:0] OFS_MATCH  = 5'h04;
  localparam logic [REG_AW-1:0] OFS_DIV    = 5'h08;
  localparam logic [REG_AW-1:0] OFS_SEC    = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_ENABLE = 5'h10;
  localparam logic [REG_AW-1:0] OFS_STATUS = 5'h14;
  localparam logic [REG_AW-1:0] OFS_CLEAR  = 5'h18;
  localparam logic [REG_AW-1:0] OFS_CTRL   = 5'h1C;

  // load strobes from the register decoder to the datapath
  typedef struct packed {
    logic ldPeriod;
    logic ldMatch;
    logic ldDiv;
    logic ldSec;
    logic ldClear;
  } rtcStrb_t;
endpackage

// File: rtl/rtc_sec_ctrl.sv
module rtc_sec_ctrl
  import rtc_sec_pkg::*;
#(
  parameter int PER_W = 16,
  parameter int DIV_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_DW-1:0] regWdata,
  input  logic [PER_W-1:0]  perQ,
  input  logic [ALARM_W-1:0] matchQ,
  input  logic [DIV_W-1:0]  divQ,
  input  logic [SEC_W-1:0]  secQ,
  input  logic [IRQ_N-1:0]  statQ,
  output rtcStrb_t          strb,
  output logic [IRQ_N-1:0]  enQ,
  output logic              stopQ,
  output logic [REG_DW-1:0] regRdata
);
  logic ldEnable;
  logic ldCtrl;

  always_comb begin
    strb     = '0;
    ldEnable = 1'b0;
    ldCtrl   = 1'b0;
    if (regWe) begin
      unique case (regAddr)
        OFS_PERIOD: strb.ldPeriod = 1'b1;
        OFS_MATCH:  strb.ldMatch  = 1'b1;
        OFS_DIV:    strb.ldDiv    = 1'b1;
        OFS_SEC:    strb.ldSec    = 1'b1;
        OFS_CLEAR:  strb.ldClear  = 1'b1;
        OFS_ENABLE: ldEnable      = 1'b1;
        OFS_CTRL:   ldCtrl        = 1'b1;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ   <= '0;
      stopQ <= 1'b0;
    end else begin
      if (ldEnable) enQ   <= regWdata[IRQ_N-1:0];
      if (ldCtrl)   stopQ <= regWdata[0];
    end
  end

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      OFS_PERIOD: regRdata = REG_DW'(perQ);
      OFS_MATCH:  regRdata = REG_DW'(matchQ);
      OFS_DIV:    regRdata = REG_DW'(divQ);
      OFS_SEC:    regRdata = REG_DW'(secQ);
      OFS_ENABLE: regRdata = REG_DW'(enQ);
      OFS_STATUS: regRdata = REG_DW'(statQ);
      OFS_CTRL:   regRdata = REG_DW'(stopQ);
      default:    regRdata = '0;
    endcase
  end
endmodule

// File: rtl/rtc_sec_dp.sv
module rtc_sec_dp
  import rtc_sec_pkg::*;
#(
  parameter int DIV_PERIOD = 8,
  parameter int DIV_W      = 3,
  parameter int PER_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              stopQ,
  input  rtcStrb_t          strb,
  input  logic [REG_DW-1:0] regWdata,
  output logic [DIV_W-1:0]  divQ,
  output logic [SEC_W-1:0]  secQ,
  output logic [PER_W-1:0]  perQ,
  output logic [ALARM_W-1:0] matchQ,
  output logic [IRQ_N-1:0]  statQ
);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_PERIOD - 1);

  logic             advance;
  logic             wrapEvt;
  logic [PER_W-1:0] perUnits;
  logic [PER_W-1:0] perCnt;
  logic [PER_W:0]   perCntInc;
  logic             perHit;
  logic             eqNow;
  logic             eqPrev;
  logic             almHit;
  logic [IRQ_N-1:0] setVec;
  logic [IRQ_N-1:0] clrVec;

  assign advance   = tickEn & ~stopQ;
  assign wrapEvt   = advance & (divQ >= DIV_LAST);
  assign perUnits  = perQ >> PER_SHIFT;
  assign perCntInc = {1'b0, perCnt} + 1'b1;
  assign perHit    = wrapEvt & (perUnits != '0) & (perCntInc >= {1'b0, perUnits});

  // prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            divQ <= '0;
    else if (strb.ldDiv)  divQ <= regWdata[DIV_W-1:0];
    else if (wrapEvt)     divQ <= '0;
    else if (advance)     divQ <= divQ + 1'b1;
  end

  // seconds counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            secQ <= '0;
    else if (strb.ldSec)  secQ <= regWdata[SEC_W-1:0];
    else if (wrapEvt)     secQ <= secQ + 1'b1;
  end

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perQ   <= '0;
      matchQ <= '0;
    end else begin
      if (strb.ldPeriod) perQ   <= regWdata[PER_W-1:0];
      if (strb.ldMatch)  matchQ <= regWdata[ALARM_W-1:0];
    end
  end

  // periodic event counter, in whole seconds
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           perCnt <= '0;
    else if (strb.ldPeriod)              perCnt <= '0;
    else if (perHit)                     perCnt <= '0;
    else if (wrapEvt && perUnits != '0)  perCnt <= perCntInc[PER_W-1:0];
  end

  // alarm edge detection on the coarse seconds field
  assign eqNow  = (secQ[ALARM_LSB +: ALARM_W] == matchQ);
  assign almHit = eqNow & ~eqPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) eqPrev <= 1'b1;
    else       eqPrev <= eqNow;
  end

  always_comb begin
    setVec          = '0;
    setVec[IDX_PER] = perHit;
    setVec[IDX_ALM] = almHit;
    clrVec          = strb.ldClear ? regWdata[IRQ_N-1:0] : '0;
  end

  // sticky status, set has priority over clear
  for (genvar i = 0; i < IRQ_N; i++) begin : g_stat
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          statQ[i] <= 1'b0;
      else if (setVec[i]) statQ[i] <= 1'b1;
      else if (clrVec[i]) statQ[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_sec_core.sv
module rtc_sec_core
  import rtc_sec_pkg::*;
#(
  parameter int DIV_PERIOD = 8,
  parameter int PER_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_DW-1:0] regWdata,
  output logic [REG_DW-1:0] regRdata,
  output logic              irqPeriodic,
  output logic              irqAlarm
);
  localparam int DIV_W = (DIV_PERIOD > 1) ? $clog2(DIV_PERIOD) : 1;

  rtcStrb_t          strb;
  logic [IRQ_N-1:0]  enQ;
  logic              stopQ;
  logic [DIV_W-1:0]  divQ;
  logic [SEC_W-1:0]  secQ;
  logic [PER_W-1:0]  perQ;
  logic [ALARM_W-1:0] matchQ;
  logic [IRQ_N-1:0]  statQ;

  rtc_sec_ctrl #(.PER_W(PER_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .perQ(perQ), .matchQ(matchQ), .divQ(divQ),
    .secQ(secQ), .statQ(statQ), .strb(strb), .enQ(enQ), .stopQ(stopQ),
    .regRdata(regRdata)
  );

  rtc_sec_dp #(.DIV_PERIOD(DIV_PERIOD), .DIV_W(DIV_W), .PER_W(PER_W)) u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .stopQ(stopQ), .strb(strb),
    .regWdata(regWdata), .divQ(divQ), .secQ(secQ), .perQ(perQ),
    .matchQ(matchQ), .statQ(statQ)
  );

  assign irqPeriodic = statQ[IDX_PER] & enQ[IDX_PER];
  assign irqAlarm    = statQ[IDX_ALM] & enQ[IDX_ALM];
endmodule

// File: rtl/rtc_sec_chk.sv
module rtc_sec_chk
  import rtc_sec_pkg::*;
#(
  parameter int DIV_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input rtcStrb_t          strb,
  input logic              stopQ,
  input logic [DIV_W-1:0]  divQ,
  input logic [SEC_W-1:0]  secQ,
  input logic [ALARM_W-1:0] matchQ,
  input logic [IRQ_N-1:0]  statQ,
  input logic [REG_DW-1:0] regWdata
);
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ldSec |=> (secQ == $past(secQ) || secQ == $past(secQ) + 1'b1));

  assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stopQ && !strb.ldSec && !strb.ldDiv) |=> ($stable(secQ) && $stable(divQ)));

  assert_load_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldSec |=> (secQ == $past(regWdata[SEC_W-1:0])));

  assert_no_periodic_when_stopped_R5: assert property (@(posedge clk) disable iff (!rstN)
    stopQ |=> !$rose(statQ[IDX_PER]));

  assert_alarm_on_match_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statQ[IDX_ALM]) |-> ($past(secQ[ALARM_LSB +: ALARM_W]) == $past(matchQ)));
endmodule

bind rtc_sec_core rtc_sec_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .stopQ(stopQ), .divQ(divQ),
  .secQ(secQ), .matchQ(matchQ), .statQ(statQ), .regWdata(regWdata)
);

// File: tb/tb_rtc_sec_core.sv
`timescale 1ns/1ps
module tb_rtc_sec_core;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        regWe = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irqPeriodic;
  logic        irqAlarm;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rtc_sec_core dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .irqPeriodic(irqPeriodic), .irqAlarm(irqAlarm)
  );

  // behavioural reference
  longint unsigned mDiv = 0, mSec = 0, mCnt = 0, mInt = 0, mMatch = 0;
  int unsigned mEn = 0, mStat = 0, mStop = 0;
  bit mEqPrev = 1'b1;

  always @(posedge clk) begin
    if (!rstN) begin
      mDiv = 0; mSec = 0; mCnt = 0; mInt = 0; mMatch = 0;
      mEn = 0; mStat = 0; mStop = 0; mEqPrev = 1'b1;
    end else begin
      longint unsigned nDiv, nSec, nCnt, units;
      int unsigned setBits, clr;
      bit eqNow;
      eqNow   = (((mSec >> 7) & 64'hFFFF) == mMatch);
      setBits = (eqNow && !mEqPrev) ? 2 : 0;
      mEqPrev = eqNow;
      nDiv = mDiv; nSec = mSec; nCnt = mCnt; clr = 0;
      if (tickEn && mStop == 0) begin
        if (mDiv >= 7) begin
          nDiv  = 0;
          nSec  = (mSec + 1) & 64'hFFFF_FFFF;
          units = mInt / 8;
          if (units != 0) begin
            if (mCnt + 1 >= units) begin setBits |= 1; nCnt = 0; end
            else nCnt = mCnt + 1;
          end
        end else nDiv = mDiv + 1;
      end
      if (regWe) begin
        case (regAddr)
          5'h00: begin mInt = regWdata & 32'hFFFF; nCnt = 0; end
          5'h04: mMatch = regWdata & 32'hFFFF;
          5'h08: nDiv = regWdata & 32'h7;
          5'h0C: nSec = regWdata;
          5'h10: mEn = regWdata & 32'h3;
          5'h18: clr = regWdata & 32'h3;
          5'h1C: mStop = regWdata & 32'h1;
          default: ;
        endcase
      end
      mDiv = nDiv; mSec = nSec; mCnt = nCnt;
      mStat = (mStat & ~clr) | setBits;
    end
  end

  function automatic longint unsigned mRead(input logic [4:0] a);
    case (a)
      5'h00: return mInt;
      5'h04: return mMatch;
      5'h08: return mDiv;
      5'h0C: return mSec;
      5'h10: return mEn;
      5'h14: return mStat;
      5'h1C: return mStop;
      default: return 0;
    endcase
  endfunction

  // per-cycle comparison away from the rising edge
  always @(negedge clk) begin
    #1;
    if (rstN && !finished) begin
      vectors++;
      if (regRdata != 32'(mRead(regAddr))) begin
        miscompares++;
        $display("FAIL R9 read @%0h: actual %0h expected %0h", regAddr, regRdata, mRead(regAddr));
      end
      if (irqPeriodic != (mStat[0] & mEn[0]) || irqAlarm != (mStat[1] & mEn[1])) begin
        miscompares++;
        $display("FAIL R7 irq: actual %b%b expected %b%b", irqAlarm, irqPeriodic,
                 mStat[1] & mEn[1], mStat[0] & mEn[0]);
      end
    end
  end

  task automatic check(input string tag, input longint unsigned act, input longint unsigned exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdReg(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #2;
    d = regRdata;
  endtask

  task automatic tickRun(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset values
    for (int a = 0; a < 32; a += 4) begin
      rdReg(5'(a), v);
      check("R1 reset read", v, 0);
    end
    check("R1 irq low", {irqAlarm, irqPeriodic}, 0);

    // R2: 20 ticks -> 2 seconds, divider 4
    wrReg(5'h00, 8);
    wrReg(5'h10, 3);
    tickRun(20);
    rdReg(5'h0C, v); check("R2 seconds", v, 2);
    rdReg(5'h08, v); check("R2 divider", v, 4);
    rdReg(5'h14, v); check("R5 periodic 1s", v[0], 1);
    check("R7 irqPeriodic", irqPeriodic, 1);
    wrReg(5'h18, 0);
    rdReg(5'h14, v); check("R8 zero clear", v[0], 1);
    wrReg(5'h18, 1);
    rdReg(5'h14, v); check("R8 clear", v[0], 0);

    // R3: stop freezes counting
    wrReg(5'h1C, 1);
    tickRun(50);
    rdReg(5'h0C, v); check("R3 seconds held", v, 2);
    rdReg(5'h08, v); check("R3 divider held", v, 4);
    rdReg(5'h14, v); check("R3 no periodic", v[0], 0);

    // R6: alarm at field 5 (seconds 640)
    wrReg(5'h08, 0);
    wrReg(5'h0C, 638);
    wrReg(5'h04, 5);
    wrReg(5'h18, 3);
    wrReg(5'h1C, 0);
    tickRun(16);
    rdReg(5'h14, v); check("R6 alarm set", v[1], 1);
    check("R7 irqAlarm", irqAlarm, 1);
    wrReg(5'h18, 2);
    tickRun(40);
    rdReg(5'h14, v); check("R6 no refire", v[1], 0);

    // R5: 3-second interval, then a sub-second interval
    wrReg(5'h00, 24);
    wrReg(5'h18, 1);
    tickRun(16);
    rdReg(5'h14, v); check("R5 not yet", v[0], 0);
    tickRun(8);
    rdReg(5'h14, v); check("R5 third second", v[0], 1);
    wrReg(5'h00, 4);
    wrReg(5'h18, 1);
    tickRun(80);
    rdReg(5'h14, v); check("R5 interval<8", v[0], 0);

    // R7: status without enable
    wrReg(5'h10, 0);
    wrReg(5'h00, 8);
    tickRun(8);
    rdReg(5'h14, v); check("R7 status polled", v[0], 1);
    check("R7 irq masked", irqPeriodic, 0);

    // R8: set and clear in the same cycle
    wrReg(5'h1C, 1);
    wrReg(5'h08, 7);
    wrReg(5'h00, 8);
    wrReg(5'h18, 3);
    wrReg(5'h1C, 0);
    @(negedge clk);
    tickEn = 1'b1; regWe = 1'b1; regAddr = 5'h18; regWdata = 1;
    @(negedge clk);
    tickEn = 1'b0; regWe = 1'b0;
    rdReg(5'h14, v); check("R8 set wins", v[0], 1);
    rdReg(5'h18, v); check("R8 clear reads 0", v, 0);

    // R4: load wins over increment
    wrReg(5'h08, 7);
    @(negedge clk);
    tickEn = 1'b1; regWe = 1'b1; regAddr = 5'h0C; regWdata = 100;
    @(negedge clk);
    tickEn = 1'b0; regWe = 1'b0;
    rdReg(5'h0C, v); check("R4 seconds load", v, 100);
    rdReg(5'h08, v); check("R4 divider wrapped", v, 0);
    wrReg(5'h08, 32'hFFFF_FFFD);
    rdReg(5'h08, v); check("R4 divider low bits", v, 5);

    // R9: read-only status and unmapped offsets
    wrReg(5'h14, 0);
    rdReg(5'h14, v); check("R9 status read-only", v[0], 1);
    wrReg(5'h06, 32'hFFFF);
    rdReg(5'h04, v); check("R9 match kept", v, 5);
    rdReg(5'h06, v); check("R9 unmapped read", v, 0);
    wrReg(5'h1E, 1);
    rdReg(5'h1C, v); check("R9 ctrl kept", v, 0);
    rdReg(5'h00, v); check("R9 interval readback", v, 8);

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule